// File: doc/BRIEF.md
# Half-Step Prescaled Baud Rate Generator

This block derives the timing strobes for an asynchronous serial port from the system clock. A 5-bit prescaler code selects a divide factor between 1 and 16 in steps of one half. Code zero freezes the generator. The prescaler output drives a programmable divisor counter that divides by (divisor + 1). That counter gives the oversample strobe, which runs at sixteen times the bit rate. A last divide by sixteen gives the bit strobe.

Half-step factors come from alternating the prescaler interval between the floor and the ceiling of the factor. The mean period is therefore exact over any two intervals. Both settings are loaded through a small write port. Any write restarts every counter from its new terminal value, so the strobe timing after a reconfiguration is deterministic.

Top module: `fracbaud_gen`

## Requirements
- R1: After reset the prescaler code and the divisor are both 0, and neither `os_tick` nor `bit_tick` is asserted.
- R2: While the prescaler code is 0, `os_tick` and `bit_tick` stay low for as long as the code is held.
- R3: For a prescaler code c of 1 to 31 the factor is (c+1)/2. An odd code gives a fixed interval of (c+1)/2 clocks between prescaler strobes. An even code gives intervals that alternate between c/2 and c/2+1 clocks, starting with the shorter one after a restart.
- R4: `os_tick` is asserted on every (d+1)-th prescaler strobe, where d is the divisor. Any two consecutive `os_tick` intervals therefore total exactly (c+1)*(d+1) clocks.
- R5: `bit_tick` is asserted only together with `os_tick`, on every 16th `os_tick`. Its period is therefore exactly 8*(c+1)*(d+1) clocks.
- R6: A write on the configuration port restarts all counters. No strobe appears in the cycle after the write edge. Counting from the write edge, the first `os_tick` follows after the sum of the first d+1 prescaler intervals given by R3. The first `bit_tick` follows after the sum of the first 16*(d+1) intervals.
- R7: A write with `cfg_addr`=0 loads the prescaler code from `cfg_wdata[4:0]` and ignores the upper bits. A write with `cfg_addr`=1 loads the divisor from all of `cfg_wdata`. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = prescaler code, 1 = baud divisor |
| cfg_wdata | input | DIV_W | Write data |
| os_tick | output | 1 | Oversample strobe at 16x the bit rate |
| bit_tick | output | 1 | Bit-rate strobe |

## Verification
Every prescaler code from 1 to 31 is measured with divisors 0, 1 and 4. The span of eight consecutive oversample intervals must equal 4*(c+1)*(d+1) exactly. This separates a correct half-step alternation from an interval that is always rounded up or down, and from a divisor that is off by one. Restart latency is measured for odd and even codes, and it shows whether the shorter interval comes first. The bit strobe period is checked for an odd code and an even code. Code 0 and the reset state are watched for stray strobes. A prescaler write with the upper data bits set shows whether the code field is masked.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
   localparam int CODE_W = 5;

   typedef enum logic {
      CFG_PRESCALE = 1'b0,
      CFG_DIVISOR  = 1'b1
   } cfg_addr_e;

   // floor of (code+1)/2 : shorter prescaler interval
   function automatic logic [CODE_W-1:0] short_len(input logic [CODE_W-1:0] code);
      logic [CODE_W:0] halves;
      halves = {1'b0, code} + 1'b1;
      return halves[CODE_W:1];
   endfunction

   // ceiling of (code+1)/2 : longer prescaler interval
   function automatic logic [CODE_W:0] long_len(input logic [CODE_W-1:0] code);
      logic [CODE_W:0] halves;
      halves = {1'b0, code} + 1'b1;
      return {1'b0, halves[CODE_W:1]} + {{CODE_W{1'b0}}, halves[0]};
   endfunction
endpackage

// File: rtl/bg_cfg_port.sv
module bg_cfg_port
   import baudgen_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic                addr,
   input  logic [DIV_W-1:0]    wdata,
   output logic [CODE_W-1:0]   code,
   output logic [DIV_W-1:0]    divisor,
   output logic                restart
);
   cfg_addr_e sel;
   assign sel = cfg_addr_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code    <= '0;
         divisor <= '0;
         restart <= 1'b0;
      end else begin
         restart <= we;
         if (we) begin
            case (sel)
               CFG_PRESCALE: code    <= wdata[CODE_W-1:0];
               CFG_DIVISOR:  divisor <= wdata;
               default:      ;
            endcase
         end
      end
   end
endmodule

// File: rtl/bg_half_prescaler.sv
module bg_half_prescaler
   import baudgen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   logic [CODE_W-1:0] cnt_q;
   logic              long_phase_q;
   logic              run;
   logic [CODE_W-1:0] short_m1;
   logic [CODE_W:0]   long_m1;

   assign run      = (code != '0);
   assign short_m1 = short_len(code) - 1'b1;
   assign long_m1  = long_len(code) - 1'b1;
   assign tick     = run && !load && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q        <= '0;
         long_phase_q <= 1'b0;
      end else if (load) begin
         cnt_q        <= run ? short_m1 : '0;
         long_phase_q <= 1'b0;
      end else if (tick) begin
         cnt_q        <= long_phase_q ? short_m1 : long_m1[CODE_W-1:0];
         long_phase_q <= ~long_phase_q;
      end else if (run) begin
         cnt_q        <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/bg_tick_div.sv
module bg_tick_div #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] reload,
   output logic         done
);
   logic [W-1:0] cnt_q;

   assign done = step && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load)  cnt_q <= reload;
      else if (step)  cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
   end
endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen
   import baudgen_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int OS_RATIO = 16,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_addr,
   input  logic [DIV_W-1:0] cfg_wdata,
   output logic             os_tick,
   output logic             bit_tick
);
   localparam int OS_W = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;
   localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATIO - 1);

   if (DIV_W < CODE_W) begin : g_bad_div_w
      $error("DIV_W must be at least the prescaler code width");
   end
   if (OS_RATIO < 2 || (OS_RATIO & (OS_RATIO - 1)) != 0) begin : g_bad_ratio
      $error("OS_RATIO must be a power of two of at least 2");
   end

   logic [CODE_W-1:0] code;
   logic [DIV_W-1:0]  divisor;
   logic              restart;
   logic              pre_tick;
   logic              os_raw;
   logic              bit_raw;

   bg_cfg_port #(.DIV_W(DIV_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .code(code), .divisor(divisor), .restart(restart)
   );

   bg_half_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .load(restart), .code(code), .tick(pre_tick)
   );

   bg_tick_div #(.W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .load(restart), .step(pre_tick),
      .reload(divisor), .done(os_raw)
   );

   bg_tick_div #(.W(OS_W)) u_bit (
      .clk(clk), .rst_n(rst_n), .load(restart), .step(os_raw),
      .reload(OS_LAST), .done(bit_raw)
   );

   if (OUT_REG) begin : g_out_reg
      logic os_q, bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            os_q  <= 1'b0;
            bit_q <= 1'b0;
         end else begin
            os_q  <= os_raw;
            bit_q <= bit_raw;
         end
      end
      assign os_tick  = os_q;
      assign bit_tick = bit_q;
   end else begin : g_out_comb
      assign os_tick  = os_raw;
      assign bit_tick = bit_raw;
   end
endmodule

// File: rtl/fracbaud_gen_chk.sv
module fracbaud_gen_chk
   import baudgen_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int OS_RATIO = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              restart,
   input logic [CODE_W-1:0] code,
   input logic [DIV_W-1:0]  divisor,
   input logic              pre_tick,
   input logic              os_raw,
   input logic              bit_raw
);
   logic [CODE_W+1:0] gap_q;
   logic              ph_q;
   logic [DIV_W:0]    pre_seen_q;
   logic [15:0]       os_seen_q;
   logic [CODE_W+1:0] want_gap;

   assign want_gap = ph_q ? {1'b0, long_len(code)} : {2'b00, short_len(code)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q      <= '0;
         ph_q       <= 1'b0;
         pre_seen_q <= '0;
         os_seen_q  <= '0;
      end else if (restart) begin
         gap_q      <= '0;
         ph_q       <= 1'b0;
         pre_seen_q <= '0;
         os_seen_q  <= '0;
      end else begin
         if (pre_tick) begin
            gap_q <= '0;
            ph_q  <= ~ph_q;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
         end
         if (os_raw)        pre_seen_q <= '0;
         else if (pre_tick) pre_seen_q <= pre_seen_q + 1'b1;
         if (bit_raw)       os_seen_q <= '0;
         else if (os_raw)   os_seen_q <= os_seen_q + 1'b1;
      end
   end

   assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0) |-> (!os_raw && !bit_raw));

   assert_pre_interval_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pre_tick |-> ((gap_q + 1'b1) == want_gap));

   assert_os_every_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
      os_raw |-> (pre_tick && pre_seen_q == {1'b0, divisor}));

   assert_bit_in_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_raw |-> (os_raw && os_seen_q == 16'(OS_RATIO - 1)));

   assert_quiet_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (!pre_tick && !os_raw && !bit_raw));
endmodule

bind fracbaud_gen fracbaud_gen_chk #(.DIV_W(DIV_W), .OS_RATIO(OS_RATIO)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .restart(restart), .code(code),
   .divisor(divisor), .pre_tick(pre_tick), .os_raw(os_raw), .bit_raw(bit_raw)
);

// File: tb/tb_fracbaud_gen.sv
module tb_fracbaud_gen;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_W      = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic             cfg_addr = 1'b0;
   logic [DIV_W-1:0] cfg_wdata = '0;
   logic             os_tick, bit_tick;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fracbaud_gen #(.DIV_W(DIV_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .os_tick(os_tick), .bit_tick(bit_tick)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one write; returns just after the capturing edge (at its negedge)
   task automatic cfg_write(input logic a, input int d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = DIV_W'(d);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // model of the R3 interval sequence after restart
   function automatic int interval_sum(input int c, input int n);
      int s = 0;
      for (int i = 0; i < n; i++)
         s += ((c % 2) == 1) ? (c + 1) / 2 : ((i % 2) == 0 ? c / 2 : c / 2 + 1);
      return s;
   endfunction

   task automatic wait_os(output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!os_tick && cyc < 20000);
   endtask

   task automatic t_reset;
      int seen = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (os_tick || bit_tick) seen++;
      end
      check("R1 no strobes after reset", seen, 0);
   endtask

   // R3/R4: span of 8 oversample intervals equals 4*(c+1)*(d+1)
   task automatic t_span(input int c, input int d, input string tag);
      int cyc, total;
      cfg_write(1'b0, c);
      cfg_write(1'b1, d);
      wait_os(cyc);
      total = 0;
      for (int k = 0; k < 8; k++) begin
         wait_os(cyc);
         total += cyc;
      end
      check($sformatf("%s span code=%0d div=%0d", tag, c, d), total, 4 * (c + 1) * (d + 1));
   endtask

   // R6: latency from write edge to first os_tick and first bit_tick
   task automatic t_restart(input int c, input int d);
      int k = 0, k_os = -1, k_bit = -1;
      cfg_write(1'b0, c);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = DIV_W'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      check("R6 quiet in restart cycle", int'(os_tick | bit_tick), 0);
      while (k_bit < 0 && k < 40000) begin
         @(negedge clk);
         k++;
         if (os_tick && k_os < 0) k_os = k;
         if (bit_tick) k_bit = k;
      end
      check($sformatf("R6 first os_tick code=%0d div=%0d", c, d), k_os, interval_sum(c, d + 1));
      check($sformatf("R6 first bit_tick code=%0d div=%0d", c, d), k_bit, interval_sum(c, 16 * (d + 1)));
   endtask

   // R5: bit strobe period and coincidence with os_tick
   task automatic t_bit(input int c, input int d);
      int cyc = 0, stray = 0, per = 0;
      cfg_write(1'b0, c);
      cfg_write(1'b1, d);
      while (!bit_tick && cyc < 40000) begin @(negedge clk); cyc++; end
      do begin
         @(negedge clk);
         per++;
         if (bit_tick && !os_tick) stray++;
      end while (!bit_tick && per < 40000);
      check($sformatf("R5 bit period code=%0d div=%0d", c, d), per, 8 * (c + 1) * (d + 1));
      check("R5 bit_tick only with os_tick", stray, 0);
   endtask

   task automatic t_stop;
      int seen = 0;
      cfg_write(1'b0, 0);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (os_tick || bit_tick) seen++;
      end
      check("R2 code 0 stops strobes", seen, 0);
   endtask

   // R7: upper data bits ignored for the code; divisor write keeps the code
   task automatic t_fields;
      int cyc, total = 0;
      cfg_write(1'b1, 2);
      cfg_write(1'b0, 8'hE3);           // code field 3 -> factor 2
      wait_os(cyc);
      for (int k = 0; k < 4; k++) begin wait_os(cyc); total += cyc; end
      check("R7 masked code field span", total, 2 * 4 * 3);
      cfg_write(1'b1, 0);               // code must stay 3
      total = 0;
      wait_os(cyc);
      for (int k = 0; k < 4; k++) begin wait_os(cyc); total += cyc; end
      check("R7 divisor write keeps code", total, 2 * 4 * 1);
   endtask

   initial begin
      #(CLK_PERIOD * 180000);
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      for (int c = 1; c < 32; c++) begin
         t_span(c, 0, "R3");
         t_span(c, 1, "R4");
         t_span(c, 4, "R4");
      end
      t_restart(3, 2);
      t_restart(4, 1);
      t_restart(2, 0);
      t_bit(5, 1);
      t_bit(6, 2);
      t_stop();
      t_fields();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule